// File: doc/BRIEF.md
# Four-Register Summation Combiner Keystream Core

This block produces a binary keystream, one bit per enabled clock. Four maximum-length binary shift registers of lengths 25, 31, 33 and 39 (128 state bits in all) advance together. One bit is taken from each register every cycle. The four bits are added as integers together with a 2-bit carry value. The low bit of that sum is the keystream bit. The high part of the sum drives the next carry through a short linear recurrence over the current and previous carry.

The core has no key-setup logic of its own. An outside sequencer writes every state bit through a parallel load port and then raises the step enable to run the generator. The keystream bit is a combinational function of the present state, so it is valid in the cycle before the step that consumes it. Payload mixing and packet framing are handled elsewhere.

Top module: `ks_core`

## Requirements
- R1: While rst_ni is low, all register bits and both carries are 0, so ks_o is 0.
- R2: A cycle with load_i high writes all state at the next rising edge. Register 1 takes lfsr_load_i[24:0], register 2 takes [55:25], register 3 takes [88:56] and register 4 takes [127:89]. The current carry takes carry_load_i and the previous carry takes carry_prev_load_i. lfsr_state_o shows the registers in the same packing.
- R3: When load_i and step_i are both high, the load wins and no step takes place.
- R4: When load_i and step_i are both low, every state bit holds and ks_o does not change.
- R5: On a step, bit i+1 of each register takes bit i, and bit 0 takes the XOR of the bits at positions (e-1) for each nonconstant exponent e of that register's polynomial: x^25+x^20+x^12+x^8+1, x^31+x^24+x^16+x^12+1, x^33+x^28+x^24+x^4+1 and x^39+x^36+x^28+x^4+1.
- R6: The output bits are bit 24 of registers 1 and 2 and bit 32 of registers 3 and 4. ks_o is bit 0 of the integer sum s of those four bits plus the current carry, read as 2*carry[1]+carry[0].
- R7: On a step, the previous carry takes the current carry. The current carry becomes u XOR c XOR T(p), where u = floor(s/2), c is the current carry, p is the previous carry, and T maps (hi,lo) to (lo, hi XOR lo).
- R8: ks_o always equals the XOR of the four output bits with carry_o[0].
- R9: An all-zero state with zero carries stays all zero under stepping, and its output stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Parallel load strobe |
| step_i | input | 1 | Step enable |
| lfsr_load_i | input | 128 | Load value for the four registers |
| carry_load_i | input | 2 | Load value for the current carry |
| carry_prev_load_i | input | 2 | Load value for the previous carry |
| ks_o | output | 1 | Keystream bit for the present state |
| lfsr_state_o | output | 128 | Present register contents |
| carry_o | output | 2 | Present current carry |
| carry_prev_o | output | 2 | Present previous carry |

## Verification
The assertions assume that the control inputs are clean binary values at every rising edge after reset and that the load value is stable around the edge where it is captured. The bench drives all inputs only on falling edges and keeps load and step at known levels at all times, including the cycle where both are high. A bench model built on integer addition predicts each keystream bit and the full state after long runs from several seeds. These seeds include all-ones, single-bit and nonzero-carry cases.

// File: rtl/ks_pkg.sv
package ks_pkg;
  localparam int NUM_REG = 4;
  localparam int REG_LEN [NUM_REG] = '{25, 31, 33, 39};
  localparam int EXP_A   [NUM_REG] = '{20, 24, 28, 36};
  localparam int EXP_B   [NUM_REG] = '{12, 16, 24, 28};
  localparam int EXP_C   [NUM_REG] = '{8, 12, 4, 4};
  localparam int OUT_POS [NUM_REG] = '{24, 24, 32, 32};
  localparam int CW = 2;

  function automatic int reg_base(int k);
    int acc = 0;
    for (int i = 0; i < k; i++) acc += REG_LEN[i];
    return acc;
  endfunction

  localparam int STATE_W = reg_base(NUM_REG);
endpackage

// File: rtl/lfsr_stage.sv
module lfsr_stage #(
  parameter int LEN     = 25,
  parameter int EXP_A   = 20,
  parameter int EXP_B   = 12,
  parameter int EXP_C   = 8,
  parameter int OUT_POS = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic           step_i,
  input  logic [LEN-1:0] load_val_i,
  output logic [LEN-1:0] state_o,
  output logic           bit_o
);
  logic [LEN-1:0] r_q;
  logic           fb;

  assign fb = r_q[LEN-1] ^ r_q[EXP_A-1] ^ r_q[EXP_B-1] ^ r_q[EXP_C-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     r_q <= '0;
    else if (load_i) r_q <= load_val_i;
    else if (step_i) r_q <= {r_q[LEN-2:0], fb};
  end

  assign state_o = r_q;
  assign bit_o   = r_q[OUT_POS];
endmodule

// File: rtl/sum_combiner.sv
module sum_combiner
  import ks_pkg::*;
#(
  parameter int NIN = NUM_REG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [NIN-1:0] x_i,
  input  logic [CW-1:0] c_load_i,
  input  logic [CW-1:0] p_load_i,
  output logic          ks_o,
  output logic [CW-1:0] c_o,
  output logic [CW-1:0] p_o
);
  localparam int SW = $clog2(NIN + 4);

  logic [CW-1:0] c_q, p_q, c_nx, u, t_p;
  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(c_q);
    for (int i = 0; i < NIN; i++) sum = sum + SW'(x_i[i]);
  end

  assign ks_o = sum[0];
  assign u    = sum[CW:1];
  // (hi,lo) -> (lo, hi^lo)
  assign t_p  = {p_q[0], p_q[1] ^ p_q[0]};
  assign c_nx = u ^ c_q ^ t_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c_q <= '0;
      p_q <= '0;
    end else if (load_i) begin
      c_q <= c_load_i;
      p_q <= p_load_i;
    end else if (step_i) begin
      c_q <= c_nx;
      p_q <= c_q;
    end
  end

  assign c_o = c_q;
  assign p_o = p_q;
endmodule

// File: rtl/ks_core.sv
module ks_core
  import ks_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               step_i,
  input  logic [STATE_W-1:0] lfsr_load_i,
  input  logic [CW-1:0]      carry_load_i,
  input  logic [CW-1:0]      carry_prev_load_i,
  output logic               ks_o,
  output logic [STATE_W-1:0] lfsr_state_o,
  output logic [CW-1:0]      carry_o,
  output logic [CW-1:0]      carry_prev_o
);
  logic [NUM_REG-1:0] tap_bits;

  for (genvar g = 0; g < NUM_REG; g++) begin : g_reg
    localparam int LEN  = REG_LEN[g];
    localparam int BASE = reg_base(g);
    lfsr_stage #(
      .LEN(LEN), .EXP_A(EXP_A[g]), .EXP_B(EXP_B[g]),
      .EXP_C(EXP_C[g]), .OUT_POS(OUT_POS[g])
    ) u_reg (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
      .load_val_i(lfsr_load_i[BASE +: LEN]),
      .state_o(lfsr_state_o[BASE +: LEN]),
      .bit_o(tap_bits[g])
    );
  end

  sum_combiner #(.NIN(NUM_REG)) u_comb (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
    .x_i(tap_bits), .c_load_i(carry_load_i), .p_load_i(carry_prev_load_i),
    .ks_o(ks_o), .c_o(carry_o), .p_o(carry_prev_o)
  );
endmodule

// File: rtl/ks_core_chk.sv
module ks_core_chk
  import ks_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               load_i,
  input logic               step_i,
  input logic [STATE_W-1:0] lfsr_load_i,
  input logic [CW-1:0]      carry_load_i,
  input logic [CW-1:0]      carry_prev_load_i,
  input logic               ks_o,
  input logic [STATE_W-1:0] lfsr_state_o,
  input logic [CW-1:0]      carry_o,
  input logic [CW-1:0]      carry_prev_o
);
  localparam int T1 = reg_base(0) + OUT_POS[0];
  localparam int T2 = reg_base(1) + OUT_POS[1];
  localparam int T3 = reg_base(2) + OUT_POS[2];
  localparam int T4 = reg_base(3) + OUT_POS[3];

  // R2
  load_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (lfsr_state_o == $past(lfsr_load_i)) && (carry_o == $past(carry_load_i))
               && (carry_prev_o == $past(carry_prev_load_i)));
  // R3
  load_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && step_i) |=> lfsr_state_o == $past(lfsr_load_i));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(lfsr_state_o) && $stable(carry_o)
                             && $stable(carry_prev_o) && $stable(ks_o));
  // R5
  shift_r1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (lfsr_state_o[24:1] == $past(lfsr_state_o[23:0]))
      && (lfsr_state_o[0] == ($past(lfsr_state_o[24]) ^ $past(lfsr_state_o[19])
                              ^ $past(lfsr_state_o[11]) ^ $past(lfsr_state_o[7]))));
  // R7
  prev_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> carry_prev_o == $past(carry_o));
  // R8
  xor_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_o == (lfsr_state_o[T1] ^ lfsr_state_o[T2] ^ lfsr_state_o[T3]
             ^ lfsr_state_o[T4] ^ carry_o[0]));
  // R9
  zero_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && lfsr_state_o == '0 && carry_o == '0 && carry_prev_o == '0)
      |=> (lfsr_state_o == '0) && (carry_o == '0) && !ks_o);
endmodule

bind ks_core ks_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load_i), .step_i(step_i),
  .lfsr_load_i(lfsr_load_i), .carry_load_i(carry_load_i),
  .carry_prev_load_i(carry_prev_load_i), .ks_o(ks_o),
  .lfsr_state_o(lfsr_state_o), .carry_o(carry_o), .carry_prev_o(carry_prev_o)
);

// File: tb/tb_ks_core.sv
`timescale 1ns/1ps
module tb_ks_core;
  logic         clk_i = 0, rst_ni = 0, load_i = 0, step_i = 0;
  logic [127:0] lfsr_load_i = '0;
  logic [1:0]   carry_load_i = '0, carry_prev_load_i = '0;
  logic         ks_o;
  logic [127:0] lfsr_state_o;
  logic [1:0]   carry_o, carry_prev_o;

  int checks = 0, errors = 0;

  ks_core dut (.*);

  always #2.5 clk_i = ~clk_i;

  // {lfsr, carry, carry_prev}
  localparam int NVEC = 6;
  localparam logic [131:0] VEC [NVEC] = '{
    {128'h0123456789abcdef_fedcba9876543210, 2'd0, 2'd0},
    {128'hffffffffffffffff_ffffffffffffffff, 2'd3, 2'd3},
    {128'h0000000000000000_0000000000000001, 2'd2, 2'd1},
    {128'h8000000001000000_0100000001000000, 2'd1, 2'd2},
    {128'hdeadbeefcafef00d_5a5a5a5aa5a5a5a5, 2'd3, 2'd0},
    {128'h0000000000000000_0000000000000000, 2'd0, 2'd3}
  };

  localparam int MLEN [4] = '{25, 31, 33, 39};
  localparam int MBAS [4] = '{0, 25, 56, 89};
  localparam int MA   [4] = '{20, 24, 28, 36};
  localparam int MB   [4] = '{12, 16, 24, 28};
  localparam int MC   [4] = '{8, 12, 4, 4};
  localparam int MO   [4] = '{24, 24, 32, 32};

  logic [38:0] m_r [4];
  int          m_c, m_p;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] m_pack();
    logic [127:0] v = '0;
    for (int k = 0; k < 4; k++)
      for (int i = 0; i < MLEN[k]; i++) v[MBAS[k]+i] = m_r[k][i];
    return v;
  endfunction

  task automatic m_load(logic [127:0] v, int c, int p);
    for (int k = 0; k < 4; k++) begin
      m_r[k] = '0;
      for (int i = 0; i < MLEN[k]; i++) m_r[k][i] = v[MBAS[k]+i];
    end
    m_c = c; m_p = p;
  endtask

  function automatic int m_sum();
    int s = m_c;
    for (int k = 0; k < 4; k++) s += int'(m_r[k][MO[k]]);
    return s;
  endfunction

  task automatic m_step();
    int s, u, t, nc;
    logic fb;
    s = m_sum();
    u = s / 2;
    t = ((m_p % 2) * 2) + ((m_p / 2) ^ (m_p % 2));
    nc = u ^ m_c ^ t;
    m_p = m_c; m_c = nc;
    for (int k = 0; k < 4; k++) begin
      fb = m_r[k][MLEN[k]-1] ^ m_r[k][MA[k]-1] ^ m_r[k][MB[k]-1] ^ m_r[k][MC[k]-1];
      m_r[k] = (m_r[k] << 1) | 39'(fb);
      m_r[k][38:0] = m_r[k] & ((39'd1 << MLEN[k]) - 39'd1);
    end
  endtask

  task automatic do_load(logic [127:0] v, logic [1:0] c, logic [1:0] p, logic stp);
    lfsr_load_i = v; carry_load_i = c; carry_prev_load_i = p;
    load_i = 1; step_i = stp;
    @(negedge clk_i);
    load_i = 0; step_i = 0;
    m_load(v, c, p);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic xr;
    logic [127:0] snap;
    repeat (3) @(negedge clk_i);
    // R1
    chk("R1 state", lfsr_state_o, 0);
    chk("R1 carry", {carry_o, carry_prev_o}, 0);
    chk("R1 ks", ks_o, 0);
    rst_ni = 1;
    @(negedge clk_i);

    for (int n = 0; n < NVEC; n++) begin
      do_load(VEC[n][131:4], VEC[n][3:2], VEC[n][1:0], 1'b0);
      // R2
      chk("R2 state", lfsr_state_o, VEC[n][131:4]);
      chk("R2 carry", {carry_o, carry_prev_o}, VEC[n][3:0]);
      step_i = 1;
      for (int t = 0; t < 300; t++) begin
        // R6
        chk("R6 ks", ks_o, m_sum() % 2);
        xr = carry_o[0];
        for (int k = 0; k < 4; k++) xr ^= lfsr_state_o[MBAS[k]+MO[k]];
        // R8
        chk("R8 xor", ks_o, xr);
        @(negedge clk_i);
        m_step();
      end
      step_i = 0;
      // R5
      chk("R5 state", lfsr_state_o, m_pack());
      // R7
      chk("R7 carry", {carry_o, carry_prev_o}, {2'(m_c), 2'(m_p)});
    end

    // R7 hand case: all taps 1, c=3, p=2 -> s=7, ks=1, next c=1, p=3
    snap = '0;
    for (int k = 0; k < 4; k++) snap[MBAS[k]+MO[k]] = 1'b1;
    do_load(snap, 2'd3, 2'd2, 1'b0);
    chk("R6 hand ks", ks_o, 1);
    step_i = 1; @(negedge clk_i); step_i = 0;
    chk("R7 hand", {carry_o, carry_prev_o}, {2'd1, 2'd3});

    // R3
    do_load(VEC[0][131:4], 2'd2, 2'd1, 1'b1);
    chk("R3 state", lfsr_state_o, VEC[0][131:4]);
    chk("R3 carry", {carry_o, carry_prev_o}, {2'd2, 2'd1});

    // R4
    snap = lfsr_state_o; xr = ks_o;
    repeat (5) @(negedge clk_i);
    chk("R4 state", lfsr_state_o, snap);
    chk("R4 carry", {carry_o, carry_prev_o}, {2'd2, 2'd1});
    chk("R4 ks", ks_o, xr);

    // R9
    do_load('0, 2'd0, 2'd0, 1'b0);
    step_i = 1;
    for (int t = 0; t < 20; t++) begin
      chk("R9 ks", ks_o, 0);
      @(negedge clk_i);
    end
    step_i = 0;
    chk("R9 state", {lfsr_state_o, carry_o, carry_prev_o}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule